// File: doc/BRIEF.md
# DMA Cycle-Stealing Controller

The block moves a block of words between a byte-wide peripheral and word-wide memory while the processor keeps running. Software programs a start address and a word count through a small select/strobe register port. It then writes the control register with a direction bit and a start bit. From that point the controller works on its own. It exchanges bytes with the device through a request/acknowledge pair. It takes the memory bus for one word at a time through a bus request/grant pair, and it flags completion with an interrupt.

Toward memory (device to memory) the controller collects two bytes into a word, little-endian, then steals one memory cycle to write the word. Toward the device (memory to device) it steals one memory cycle to read a word, then hands the device its low byte first and its high byte second. After every word access it drops its bus request, so the processor can win the bus back between words. The memory address, write data and strobe lines are released to high impedance whenever the controller does not hold the grant.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After reset irq_o, breq_o and dack_o are 0, and reading the status register returns 0.
- R2: With cs_i high, rs_i selects a register: 0 is the address, 1 is the word count, 2 is control (bit 0 is direction, 0 for device-to-memory and 1 for memory-to-device; bit 1 starts a transfer when written as 1), and 3 is status (bit 0 busy, bit 1 done). A write takes effect when wr_i is high at a clock edge. While rd_i is high, cpu_rdata_o shows the selected register's current value; otherwise it shows 0.
- R3: In device-to-memory mode the first byte taken from the device lands in bits 7:0 of the word and the second byte lands in bits 15:8.
- R4: Each memory word access increments the address register by 1 and decrements the word count by 1.
- R5: In memory-to-device mode each word read from memory goes to the device as two bytes on dev_data_o, bits 7:0 first and then bits 15:8. One byte moves in each cycle in which dack_o is high.
- R6: A memory access happens only in a cycle where both breq_o and bgnt_i are high. In that cycle mem_wr_o is 1 and mem_rd_o is 0 for device-to-memory, and the reverse for memory-to-device. mem_addr_o carries the current address. Outside that cycle the address, write data and strobe lines are high impedance.
- R7: breq_o is low in the cycle after every word access.
- R8: When the last word has been written (device-to-memory) or its last byte has been delivered (memory-to-device), done and irq_o become 1 and busy becomes 0.
- R9: Reading the status register clears done and irq_o. If completion falls in the same cycle as that read, done and irq_o stay set.
- R10: A start with a word count of 0 sets done and irq_o on the next cycle without raising breq_o.
- R11: While busy, writes to the address, count and control registers are ignored, and a repeated start has no effect.
- R12: dack_o is high only while busy and while dreq_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register port select |
| rs_i | input | 2 | Register index |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| cpu_wdata_i | input | 16 | Register write data |
| cpu_rdata_o | output | 16 | Register read data |
| irq_o | output | 1 | Completion interrupt |
| dreq_i | input | 1 | Device ready to exchange a byte |
| dack_o | output | 1 | Byte exchanged this cycle |
| dev_data_i | input | 8 | Byte from device |
| dev_data_o | output | 8 | Byte to device |
| breq_o | output | 1 | Memory bus request |
| bgnt_i | input | 1 | Memory bus grant |
| mem_addr_o | output | 16 | Memory address, high impedance when not granted |
| mem_wdata_o | output | 16 | Memory write data, high impedance when not writing |
| mem_rdata_i | input | 16 | Memory read data |
| mem_rd_o | output | 1 | Memory read strobe, high impedance when not granted |
| mem_wr_o | output | 1 | Memory write strobe, high impedance when not granted |

## Verification
Two events can land on the same clock edge: the final word access, which sets done and the interrupt, and a processor status read, which clears them. The bench holds back the grant for the last word and then opens it in the same cycle as it raises a status read. It judges the result three ways. The read must return busy without done. The interrupt must be high after that edge. A second status read must then return done and clear the interrupt.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
  typedef enum logic [1:0] {S_IDLE, S_DEV, S_BUS} seq_state_e;

  localparam logic [1:0] RS_ADDR  = 2'd0;
  localparam logic [1:0] RS_COUNT = 2'd1;
  localparam logic [1:0] RS_CTRL  = 2'd2;
  localparam logic [1:0] RS_STAT  = 2'd3;

  localparam int CTRL_DIR_BIT  = 0;
  localparam int CTRL_GO_BIT   = 1;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DONE_BIT = 1;
endpackage

// File: rtl/dma_steal_regs.sv
module dma_steal_regs
  import dma_steal_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic [1:0]       rs_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             busy_i,
  input  logic             word_step_i,
  input  logic             finish_i,
  output logic [REG_W-1:0] addr_o,
  output logic             cnt_zero_o,
  output logic             cnt_last_o,
  output logic             dir_o,
  output logic             go_o,
  output logic             go_dir_o,
  output logic             done_o
);
  logic [REG_W-1:0] addr_q, cnt_q, rd_val;
  logic             dir_q, done_q;
  logic             wr_sel, rd_sel, stat_rd;

  assign wr_sel   = cs_i & wr_i;
  assign rd_sel   = cs_i & rd_i;
  assign stat_rd  = rd_sel && (rs_i == RS_STAT);
  assign go_o     = wr_sel && (rs_i == RS_CTRL) && wdata_i[CTRL_GO_BIT] && !busy_i;
  assign go_dir_o = wdata_i[CTRL_DIR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (word_step_i) begin
        addr_q <= addr_q + REG_W'(1);
        cnt_q  <= cnt_q - REG_W'(1);
      end else if (wr_sel && !busy_i) begin
        case (rs_i)
          RS_ADDR:  addr_q <= wdata_i;
          RS_COUNT: cnt_q  <= wdata_i;
          RS_CTRL:  dir_q  <= wdata_i[CTRL_DIR_BIT];
          default:  ;
        endcase
      end
      // completion outranks a concurrent status read
      if (finish_i)               done_q <= 1'b1;
      else if (stat_rd || go_o)   done_q <= 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    case (rs_i)
      RS_ADDR:  rd_val = addr_q;
      RS_COUNT: rd_val = cnt_q;
      RS_CTRL:  rd_val[CTRL_DIR_BIT] = dir_q;
      default: begin
        rd_val[STAT_BUSY_BIT] = busy_i;
        rd_val[STAT_DONE_BIT] = done_q;
      end
    endcase
  end

  assign rdata_o    = rd_sel ? rd_val : '0;
  assign addr_o     = addr_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign cnt_last_o = (cnt_q == REG_W'(1));
  assign dir_o      = dir_q;
  assign done_o     = done_q;

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_step_i |=> (cnt_q == $past(cnt_q) - REG_W'(1)) && (addr_q == $past(addr_q) + REG_W'(1)));
  assert_hold_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !word_step_i) |=> $stable(addr_q) && $stable(cnt_q) && $stable(dir_q));
  assert_done_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_i |=> done_q);
endmodule

// File: rtl/dma_steal_pack.sv
module dma_steal_pack #(
  parameter int BYTE_W = 8,
  parameter int BPW    = 2,
  localparam int WORD_W = BYTE_W * BPW,
  localparam int IDX_W  = $clog2(BPW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic              take_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [BYTE_W-1:0] dev_data_i,
  output logic [WORD_W-1:0] word_o,
  output logic [BYTE_W-1:0] dev_data_o,
  output logic              byte_last_o
);
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;

  assign byte_last_o = (idx_q == IDX_W'(BPW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      word_q <= mem_rdata_i;
      idx_q  <= '0;
    end else if (take_i) begin
      if (!dir_i) begin
        for (int b = 0; b < BPW; b++)
          if (idx_q == IDX_W'(b)) word_q[b*BYTE_W +: BYTE_W] <= dev_data_i;
      end
      idx_q <= byte_last_o ? '0 : idx_q + IDX_W'(1);
    end
  end

  always_comb begin
    dev_data_o = '0;
    for (int b = 0; b < BPW; b++)
      if (idx_q == IDX_W'(b)) dev_data_o = word_q[b*BYTE_W +: BYTE_W];
  end

  assign word_o = word_q;

  assert_pack_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !load_i && !dir_i && idx_q == '0) |=> word_q[BYTE_W-1:0] == $past(dev_data_i));
endmodule

// File: rtl/dma_steal_seq.sv
module dma_steal_seq
  import dma_steal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic go_dir_i,
  input  logic dir_i,
  input  logic cnt_zero_i,
  input  logic cnt_last_i,
  input  logic byte_last_i,
  input  logic dreq_i,
  input  logic bgnt_i,
  output logic busy_o,
  output logic dack_o,
  output logic breq_o,
  output logic acc_o,
  output logic finish_o
);
  seq_state_e state_q, state_d;

  assign busy_o = (state_q != S_IDLE);
  assign dack_o = (state_q == S_DEV) && dreq_i;
  assign breq_o = (state_q == S_BUS);
  assign acc_o  = breq_o && bgnt_i;

  always_comb begin
    state_d  = state_q;
    finish_o = 1'b0;
    case (state_q)
      S_IDLE: if (go_i) begin
        if (cnt_zero_i)    finish_o = 1'b1;
        else if (go_dir_i) state_d  = S_BUS;
        else               state_d  = S_DEV;
      end
      S_DEV: if (dack_o && byte_last_i) begin
        if (dir_i && cnt_zero_i) begin
          finish_o = 1'b1;
          state_d  = S_IDLE;
        end else begin
          state_d  = S_BUS;
        end
      end
      S_BUS: if (acc_o) begin
        if (!dir_i && cnt_last_i) begin
          finish_o = 1'b1;
          state_d  = S_IDLE;
        end else begin
          state_d  = S_DEV;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assert_zero_go_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && cnt_zero_i) |=> (state_q == S_IDLE));
  assert_finish_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> !busy_o);
endmodule

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl #(
  parameter int REG_W  = 16,
  parameter int BYTE_W = 8,
  parameter int BPW    = 2,
  localparam int WORD_W = BYTE_W * BPW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [1:0]        rs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  cpu_wdata_i,
  output logic [REG_W-1:0]  cpu_rdata_o,
  output logic              irq_o,
  input  logic              dreq_i,
  output logic              dack_o,
  input  logic [BYTE_W-1:0] dev_data_i,
  output logic [BYTE_W-1:0] dev_data_o,
  output logic              breq_o,
  input  logic              bgnt_i,
  output logic [REG_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o
);
  import dma_steal_pkg::*;

  logic [REG_W-1:0]  addr;
  logic [WORD_W-1:0] word;
  logic cnt_zero, cnt_last, dir, go, go_dir, done;
  logic busy, acc, finish, byte_last;

  dma_steal_regs #(.REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni, .cs_i, .rs_i, .rd_i, .wr_i,
    .wdata_i(cpu_wdata_i), .rdata_o(cpu_rdata_o),
    .busy_i(busy), .word_step_i(acc), .finish_i(finish),
    .addr_o(addr), .cnt_zero_o(cnt_zero), .cnt_last_o(cnt_last),
    .dir_o(dir), .go_o(go), .go_dir_o(go_dir), .done_o(done)
  );

  dma_steal_seq u_seq (
    .clk_i, .rst_ni, .go_i(go), .go_dir_i(go_dir), .dir_i(dir),
    .cnt_zero_i(cnt_zero), .cnt_last_i(cnt_last), .byte_last_i(byte_last),
    .dreq_i, .bgnt_i, .busy_o(busy), .dack_o, .breq_o,
    .acc_o(acc), .finish_o(finish)
  );

  dma_steal_pack #(.BYTE_W(BYTE_W), .BPW(BPW)) u_pack (
    .clk_i, .rst_ni, .dir_i(dir), .take_i(dack_o), .load_i(acc && dir),
    .mem_rdata_i, .dev_data_i, .word_o(word), .dev_data_o, .byte_last_o(byte_last)
  );

  assign irq_o = done;

  // bus lines float unless this cycle holds the grant
  assign mem_addr_o  = acc ? addr : {REG_W{1'bz}};
  assign mem_wdata_o = (acc && !dir) ? word : {WORD_W{1'bz}};
  assign mem_rd_o    = acc ? dir : 1'bz;
  assign mem_wr_o    = acc ? !dir : 1'bz;

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (breq_o && bgnt_i) |=> !breq_o);
  assert_irq_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && rs_i == RS_STAT && !finish) |=> !irq_o);
  assert_dack_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> (dreq_i && busy));
endmodule

// File: tb/dma_steal_ctrl_bench.sv
`timescale 1ns/1ps
module dma_steal_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cs_i = 0, rd_i = 0, wr_i = 0, dreq_i = 0, bgnt_i = 0;
  logic [1:0]  rs_i = 0;
  logic [15:0] cpu_wdata_i = 0, cpu_rdata_o, mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [7:0]  dev_data_i = 0, dev_data_o;
  logic        irq_o, dack_o, breq_o, mem_rd_o, mem_wr_o;

  dma_steal_ctrl u_dma_steal_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_i, .rs_i, .rd_i, .wr_i, .cpu_wdata_i,
    .cpu_rdata_o, .irq_o, .dreq_i, .dack_o, .dev_data_i, .dev_data_o,
    .breq_o, .bgnt_i, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_rd_o, .mem_wr_o
  );

  function automatic logic [15:0] rd_word(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C};
  endfunction
  assign mem_rdata_i = rd_word(mem_addr_o);

  int checks = 0, failures = 0;
  logic [31:0] exp_wr[$];
  logic [15:0] exp_rd[$];
  logic [7:0]  exp_byte[$];
  int gnt_delay = 0, wcnt = 0, breq_seen = 0;
  bit hold_gnt = 0, prev_acc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // arbiter, memory scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!breq_o) begin bgnt_i = 0; wcnt = 0; end
      else if (!bgnt_i) begin
        if (wcnt >= gnt_delay && !hold_gnt) bgnt_i = 1;
        else wcnt++;
      end
      #1;
      if (breq_o) breq_seen++;
      if (prev_acc) check(!breq_o, "R7", "breq after access", 32'(breq_o), 0);
      if (dack_o) check(dreq_i, "R12", "dack without dreq", 32'(dreq_i), 1);
      if (breq_o && bgnt_i) begin
        if (mem_wr_o === 1'b1 && mem_rd_o === 1'b0) begin
          if (exp_wr.size() == 0) check(0, "R6", "unexpected write", 32'(mem_addr_o), 0);
          else begin
            logic [31:0] e;
            e = exp_wr.pop_front();
            check({mem_addr_o, mem_wdata_o} == e, "R3", "write addr/data",
                  {mem_addr_o, mem_wdata_o}, e);
          end
        end else if (mem_rd_o === 1'b1 && mem_wr_o === 1'b0) begin
          if (exp_rd.size() == 0) check(0, "R6", "unexpected read", 32'(mem_addr_o), 0);
          else begin
            logic [15:0] e;
            e = exp_rd.pop_front();
            check(mem_addr_o == e, "R6", "read addr", 32'(mem_addr_o), 32'(e));
          end
        end else check(0, "R6", "strobes", {mem_rd_o, mem_wr_o}, 0);
      end
      prev_acc = breq_o && bgnt_i;
    end
  end

  task automatic cpu_write(input logic [1:0] rs, input logic [15:0] d);
    @(negedge clk);
    cs_i = 1; wr_i = 1; rs_i = rs; cpu_wdata_i = d;
    @(posedge clk); #1;
    cs_i = 0; wr_i = 0;
  endtask

  task automatic cpu_read(input logic [1:0] rs, output logic [15:0] d);
    @(negedge clk);
    cs_i = 1; rd_i = 1; rs_i = rs;
    #1 d = cpu_rdata_o;
    @(posedge clk); #1;
    cs_i = 0; rd_i = 0;
  endtask

  task automatic feed(input int n, input logic [7:0] seed);
    int got = 0, cyc = 0;
    while (got < n) begin
      @(negedge clk);
      dreq_i = (cyc % 3) != 1;
      dev_data_i = seed + 8'(got * 8'h17);
      cyc++;
      #1;
      if (dack_o) got++;
    end
    @(negedge clk); dreq_i = 0;
  endtask

  task automatic consume(input int n);
    int got = 0, cyc = 0;
    while (got < n) begin
      @(negedge clk);
      dreq_i = (cyc % 3) != 2;
      cyc++;
      #1;
      if (dack_o) begin
        logic [7:0] e;
        e = exp_byte.pop_front();
        check(dev_data_o == e, "R5", "byte to device", 32'(dev_data_o), 32'(e));
        got++;
      end
    end
    @(negedge clk); dreq_i = 0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 500 && !irq_o; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    dreq_i = 1;
    @(negedge clk); #1;
    check(irq_o == 0, "R1", "irq after reset", 32'(irq_o), 0);
    check(breq_o == 0, "R1", "breq after reset", 32'(breq_o), 0);
    check(dack_o == 0, "R12", "dack while idle", 32'(dack_o), 0);
    dreq_i = 0;
    cpu_read(2'd3, v);
    check(v == 0, "R1", "status after reset", 32'(v), 0);

    // device-to-memory, three words
    cpu_write(2'd0, 16'h0100);
    cpu_write(2'd1, 16'd3);
    cpu_read(2'd0, v); check(v == 16'h0100, "R2", "addr readback", 32'(v), 32'h100);
    cpu_read(2'd1, v); check(v == 16'd3, "R2", "count readback", 32'(v), 3);
    gnt_delay = 2;
    for (int k = 0; k < 3; k++)
      exp_wr.push_back({16'h0100 + 16'(k),
                        8'h3C + 8'((2*k+1) * 8'h17), 8'h3C + 8'((2*k) * 8'h17)});
    cpu_write(2'd2, 16'h0002);
    fork
      feed(2, 8'h3C);
    join
    begin : feed_rest
      // continue byte sequence across words
      int got = 2, cyc = 0;
      while (got < 6) begin
        @(negedge clk);
        dreq_i = (cyc % 4) != 3;
        dev_data_i = 8'h3C + 8'(got * 8'h17);
        cyc++;
        #1;
        if (dack_o) got++;
      end
      @(negedge clk); dreq_i = 0;
    end
    wait_irq();
    check(irq_o == 1, "R8", "irq after input block", 32'(irq_o), 1);
    check(exp_wr.size() == 0, "R3", "writes left", 32'(exp_wr.size()), 0);
    cpu_read(2'd3, v); check(v == 16'h0002, "R8", "status done not busy", 32'(v), 2);
    @(negedge clk); #1;
    check(irq_o == 0, "R9", "irq cleared by status read", 32'(irq_o), 0);
    cpu_read(2'd0, v); check(v == 16'h0103, "R4", "final addr", 32'(v), 32'h103);
    cpu_read(2'd1, v); check(v == 16'd0, "R4", "final count", 32'(v), 0);

    // memory-to-device, two words, with writes while busy
    cpu_write(2'd0, 16'h0200);
    cpu_write(2'd1, 16'd2);
    gnt_delay = 0;
    for (int k = 0; k < 2; k++) begin
      exp_rd.push_back(16'h0200 + 16'(k));
      exp_byte.push_back(rd_word(16'h0200 + 16'(k)) & 16'h00FF);
      exp_byte.push_back(8'(rd_word(16'h0200 + 16'(k)) >> 8));
    end
    cpu_write(2'd2, 16'h0003);
    cpu_write(2'd0, 16'h7777);
    cpu_write(2'd2, 16'h0002);
    consume(4);
    wait_irq();
    check(irq_o == 1, "R8", "irq after output block", 32'(irq_o), 1);
    check(exp_rd.size() == 0, "R6", "reads left", 32'(exp_rd.size()), 0);
    cpu_read(2'd2, v); check(v == 16'h0001, "R11", "dir kept while busy", 32'(v), 1);
    cpu_read(2'd0, v); check(v == 16'h0202, "R11", "addr write ignored while busy", 32'(v), 32'h202);
    cpu_read(2'd3, v); check(v == 16'h0002, "R8", "status after output", 32'(v), 2);

    // zero count
    cpu_write(2'd1, 16'd0);
    breq_seen = 0;
    cpu_write(2'd2, 16'h0002);
    @(negedge clk); #1;
    check(irq_o == 1, "R10", "irq on zero count", 32'(irq_o), 1);
    check(breq_seen == 0, "R10", "no bus request on zero count", 32'(breq_seen), 0);
    cpu_read(2'd3, v);

    // completion and status read in the same cycle
    cpu_write(2'd0, 16'h0300);
    cpu_write(2'd1, 16'd1);
    exp_wr.push_back({16'h0300, 8'h55 + 8'h17, 8'h55});
    hold_gnt = 1;
    cpu_write(2'd2, 16'h0002);
    feed(2, 8'h55);
    while (!breq_o) @(negedge clk);
    @(posedge clk); #1 hold_gnt = 0;
    @(negedge clk); #2;
    cs_i = 1; rd_i = 1; rs_i = 2'd3;
    #1 check(cpu_rdata_o == 16'h0001, "R9", "status in completion cycle", 32'(cpu_rdata_o), 1);
    @(negedge clk);
    cs_i = 0; rd_i = 0;
    #2 check(irq_o == 1, "R9", "completion wins over read", 32'(irq_o), 1);
    check(exp_wr.size() == 0, "R3", "collision write", 32'(exp_wr.size()), 0);
    cpu_read(2'd3, v); check(v == 16'h0002, "R9", "done kept", 32'(v), 2);
    @(negedge clk); #1;
    check(irq_o == 0, "R9", "irq cleared later", 32'(irq_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule